// File: doc/BRIEF.md
# Quad Power-Rail Enable Sequencer

This block is a synchronous controller that raises four rail-enable outputs, A through D, one after another. Each step waits a programmed number of timebase ticks. Two comparator results are digital inputs: one says the supply is above its low limit, the other says it is above its high limit. These two results, together with a sequence request, decide when the power-up may begin. A single clock-enable pulse, `tick_i`, stands in for the slow timebase, and every delay is counted in those ticks.

On a valid start the block waits the start delay and then switches A on. It then switches on B, C and D, each after its own gap. When the request is withdrawn with all rails on, the block runs the start delay again. It then switches D off and walks back down to A, using the gaps in mirrored order. A fault output shows at all times whether the supply is inside its window. If the window is lost while any rail sequencing is in progress or all rails are on, every rail drops on the next clock.

Build parameters set the polarity of the enable pins and of the request pin. A third parameter removes the request altogether: the rails then come up on voltage compliance alone and fall together only when compliance is lost.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is held and right after it, every rail is off, `state_o` is 0 (idle) and `seq_done_o` is 0. "Off" means 0 on the pin when `EN_ACTIVE_HIGH`=1 and 1 when it is 0.
- R2: `fault_o` is 1 whenever the synchronized `uv_ok_i` is 0 or the synchronized `ov_trip_i` is 1, in every state. It follows the raw pins after two clock edges.
- R3: The block leaves idle only when the supply is inside its window and the request is active. It then enters state 1 (start wait). State codes: 0 idle, 1 start wait, 2 ramp up, 3 all on, 4 stop wait, 5 ramp down.
- R4: In state 1, rail A (bit 0 of `rail_en_o`) turns on at the edge where the (`dly_start_i`+1)-th tick is seen in that state. A delay of 0 therefore advances on the first tick.
- R5: In state 2, B (bit 1), C (bit 2) and D (bit 3) turn on in that order. Each waits `dly_ab_i`+1, `dly_bc_i`+1 and `dly_cd_i`+1 ticks respectively. When D turns on, the state becomes 3 and `seq_done_o` reads 1 for as long as the block stays in state 3.
- R6: The rails always form a thermometer code (0000, 0001, 0011, 0111, 1111). While the window holds, at most one rail changes per clock.
- R7: When the request goes inactive in state 3, the block enters state 4 and waits `dly_start_i`+1 ticks, then turns D off. In state 5 it turns C off after `dly_cd_i`+1 ticks, B after `dly_bc_i`+1 and A after `dly_ab_i`+1, and then returns to idle.
- R8: The request is looked at only in states 0 and 3. Reasserting it in state 4 or 5 does not stop the shutdown; a new start can begin only once the block is back in idle.
- R9: If the synchronized window is lost in any state other than idle, all rails turn off and the state becomes 0 on the next clock edge.
- R10: With `EN_ACTIVE_HIGH`=0 the enable pins are the inverse of the rail states. With `REQ_ACTIVE_HIGH`=0 a low `seq_req_i` is an active request.
- R11: With `HAS_REQ`=0, `seq_req_i` is ignored and sequencing starts on the window alone. The block stays in state 3 until the window is lost, and then all rails drop together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase clock-enable pulse |
| uv_ok_i | input | 1 | 1 when the supply is above its low limit |
| ov_trip_i | input | 1 | 1 when the supply is above its high limit |
| seq_req_i | input | 1 | Sequence request, polarity set by `REQ_ACTIVE_HIGH` |
| dly_start_i | input | DLY_W | Start delay in ticks, also used before shutdown |
| dly_ab_i | input | DLY_W | Gap between A and B |
| dly_bc_i | input | DLY_W | Gap between B and C |
| dly_cd_i | input | DLY_W | Gap between C and D |
| rail_en_o | output | 4 | Rail enables, bit 0 = A to bit 3 = D, polarity set by `EN_ACTIVE_HIGH` |
| fault_o | output | 1 | 1 when the supply is outside its window |
| state_o | output | 3 | Sequencer state code |
| seq_done_o | output | 1 | All four rails on |

## Verification
The bench aims at the places where an off-by-one tick, a wrong mirror or a lost abort would show.

**Delay edges.** Zero delays and sparse, irregular ticks are applied. A counter that advanced on the tick it was loaded, or one tick late, would shift every rail edge against the model.

**Shutdown ordering.** The shutdown gaps are deliberately unequal. A block that reused the gaps in power-up order would turn C off after the A-B gap instead of the C-D gap.

**Window loss mid-ramp.** The window is dropped during the ramp. A design that finished the ramp, or dropped rails one by one, would still show rails on three edges later.

**Request reasserted during shutdown.** The request comes back while the rails are going down. A block that honoured it at once would jump back into the power-up before reaching idle.

**Build variants.** The inverted-polarity build and the build without a request run beside the default one on the same stimulus. This catches a missing inversion or a request input that still has an effect.

// File: rtl/rs_pkg.sv
package rs_pkg;

  localparam int NUM_RAILS = 4;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ON_WAIT  = 3'd1,
    ST_RAMP_UP  = 3'd2,
    ST_ALL_ON   = 3'd3,
    ST_OFF_WAIT = 3'd4,
    ST_RAMP_DN  = 3'd5
  } seq_state_e;

  // Gap index used by a stage: going up, stage s (1..3) waits gap s-1;
  // going down, stage s (2..0) waits gap s, so the mirror reuses each gap.
  function automatic logic [1:0] gap_index(input seq_state_e st, input logic [1:0] stage);
    if (st == ST_RAMP_UP) return stage - 2'd1;
    else                  return stage;
  endfunction

  function automatic logic [NUM_RAILS-1:0] pin_level(input logic [NUM_RAILS-1:0] on,
                                                     input bit active_high);
    return active_high ? on : ~on;
  endfunction

  function automatic logic is_timed(input seq_state_e st);
    return (st == ST_ON_WAIT) || (st == ST_RAMP_UP) ||
           (st == ST_OFF_WAIT) || (st == ST_RAMP_DN);
  endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= RST_VAL;
          else        pipe_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= RST_VAL;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/rs_delay.sv
module rs_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= '0;
    else if (run && tick)  cnt_q <= cnt_q + 1'b1;
  end

  // R4: a freshly loaded phase starts counting from zero
  a_r4_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_window,
  input  logic                 req_act,
  input  logic                 expire,
  input  logic [DLY_W-1:0]     dly_start,
  input  logic [DLY_W-1:0]     dly_ab,
  input  logic [DLY_W-1:0]     dly_bc,
  input  logic [DLY_W-1:0]     dly_cd,
  output logic [NUM_RAILS-1:0] rails,
  output seq_state_e           state,
  output logic [DLY_W-1:0]     target,
  output logic                 run,
  output logic                 load
);
  seq_state_e           st_q, st_d;
  logic [1:0]           stage_q, stage_d;
  logic [NUM_RAILS-1:0] rails_q, rails_d;

  // named events
  logic abort_evt, start_evt, stop_evt;
  assign abort_evt = (st_q != ST_IDLE) && !in_window;
  assign start_evt = (st_q == ST_IDLE) && in_window && req_act;
  assign stop_evt  = (st_q == ST_ALL_ON) && in_window && !req_act;

  always_comb begin
    target = '0;
    case (st_q)
      ST_ON_WAIT, ST_OFF_WAIT: target = dly_start;
      ST_RAMP_UP, ST_RAMP_DN: begin
        case (gap_index(st_q, stage_q))
          2'd0:    target = dly_ab;
          2'd1:    target = dly_bc;
          default: target = dly_cd;
        endcase
      end
      default: target = '0;
    endcase
  end

  assign run = is_timed(st_q);

  always_comb begin
    st_d    = st_q;
    stage_d = stage_q;
    rails_d = rails_q;
    if (abort_evt) begin
      st_d    = ST_IDLE;
      stage_d = '0;
      rails_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_evt) st_d = ST_ON_WAIT;
        ST_ON_WAIT: if (expire) begin
          rails_d[0] = 1'b1;
          stage_d    = 2'd1;
          st_d       = ST_RAMP_UP;
        end
        ST_RAMP_UP: if (expire) begin
          rails_d[stage_q] = 1'b1;
          if (stage_q == 2'd3) st_d = ST_ALL_ON;
          else                 stage_d = stage_q + 2'd1;
        end
        ST_ALL_ON: if (stop_evt) st_d = ST_OFF_WAIT;
        ST_OFF_WAIT: if (expire) begin
          rails_d[3] = 1'b0;
          stage_d    = 2'd2;
          st_d       = ST_RAMP_DN;
        end
        ST_RAMP_DN: if (expire) begin
          rails_d[stage_q] = 1'b0;
          if (stage_q == 2'd0) st_d = ST_IDLE;
          else                 stage_d = stage_q - 2'd1;
        end
        default: begin
          st_d    = ST_IDLE;
          rails_d = '0;
          stage_d = '0;
        end
      endcase
    end
  end

  assign load = (st_d != st_q) || (stage_d != stage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      stage_q <= '0;
      rails_q <= '0;
    end else begin
      st_q    <= st_d;
      stage_q <= stage_d;
      rails_q <= rails_d;
    end
  end

  assign rails = rails_q;
  assign state = st_q;

  a_r6_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    rails_q inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});

  a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |=> ($countones(rails_q ^ $past(rails_q)) <= 1));

  a_r9_abort_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && !in_window) |=> ((rails_q == '0) && (st_q == ST_IDLE)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !(in_window && req_act)) |=> (st_q == ST_IDLE));

  a_r5_done_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ALL_ON) |-> (rails_q == 4'b1111));

  a_r8_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {ST_OFF_WAIT, ST_RAMP_DN}) |=>
      (st_q inside {ST_OFF_WAIT, ST_RAMP_DN, ST_IDLE}));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rs_pkg::*;
#(
  parameter int DLY_W           = 16,
  parameter int SYNC_STAGES     = 2,
  parameter bit EN_ACTIVE_HIGH  = 1'b1,
  parameter bit REQ_ACTIVE_HIGH = 1'b1,
  parameter bit HAS_REQ         = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             uv_ok_i,
  input  logic             ov_trip_i,
  input  logic             seq_req_i,
  input  logic [DLY_W-1:0] dly_start_i,
  input  logic [DLY_W-1:0] dly_ab_i,
  input  logic [DLY_W-1:0] dly_bc_i,
  input  logic [DLY_W-1:0] dly_cd_i,
  output logic [3:0]       rail_en_o,
  output logic             fault_o,
  output logic [2:0]       state_o,
  output logic             seq_done_o
);
  localparam logic REQ_IDLE_LVL = REQ_ACTIVE_HIGH ? 1'b0 : 1'b1;

  logic [1:0] volt_s;
  logic       in_window;
  logic       req_act;

  rs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_volt_sync (
    .clk(clk), .rst_n(rst_n), .d({ov_trip_i, uv_ok_i}), .q(volt_s)
  );

  assign in_window = volt_s[0] && !volt_s[1];
  assign fault_o   = !in_window;

  generate
    if (HAS_REQ) begin : g_req
      logic req_s;
      rs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(REQ_IDLE_LVL)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(seq_req_i), .q(req_s)
      );
      assign req_act = REQ_ACTIVE_HIGH ? req_s : !req_s;
    end else begin : g_noreq
      logic unused_req;
      assign unused_req = seq_req_i;
      assign req_act    = 1'b1;
    end
  endgenerate

  logic [NUM_RAILS-1:0] rails;
  seq_state_e           state;
  logic [DLY_W-1:0]     target;
  logic                 run, load, expire;

  rs_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_window(in_window), .req_act(req_act),
    .expire(expire), .dly_start(dly_start_i), .dly_ab(dly_ab_i),
    .dly_bc(dly_bc_i), .dly_cd(dly_cd_i), .rails(rails), .state(state),
    .target(target), .run(run), .load(load)
  );

  rs_delay #(.W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run), .tick(tick_i),
    .target(target), .expire(expire)
  );

  assign rail_en_o  = pin_level(rails, EN_ACTIVE_HIGH);
  assign state_o    = state;
  assign seq_done_o = (state == ST_ALL_ON);

  // R4: every expiry must be consumed by a phase change in the controller
  a_r4_expiry_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> load);

  // R11: without a request input, the all-on state is left only through a fault
  a_r11_hold_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_REQ && state == ST_ALL_ON && in_window) |=> (state == ST_ALL_ON));
endmodule

// File: tb/rail_sequencer_test.sv
module rs_ref_model #(
  parameter bit HAS_REQ = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        uv,
  input  logic        ov,
  input  logic        req,
  input  logic [15:0] d_start,
  input  logic [15:0] d_ab,
  input  logic [15:0] d_bc,
  input  logic [15:0] d_cd,
  output logic [3:0]  rails,
  output int          st,
  output logic        fault,
  output logic        done
);
  logic u1, u2, o1, o2, r1, r2;
  int   stage, ticks;
  int   gaps [3];

  assign fault = !(u2 && !o2);
  assign done  = (st == 3);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u1 = 0; u2 = 0; o1 = 0; o2 = 0; r1 = 0; r2 = 0;
      st = 0; stage = 0; ticks = 0; rails = 0;
    end else begin
      bit win, rq;
      gaps[0] = d_ab; gaps[1] = d_bc; gaps[2] = d_cd;
      win = u2 && !o2;
      rq  = HAS_REQ ? r2 : 1'b1;
      if (st != 0 && !win) begin
        rails = 0; st = 0; stage = 0;
      end else begin
        case (st)
          0: if (win && rq) begin st = 1; ticks = 0; end
          1: if (tick) begin
               if (ticks == d_start) begin rails = 4'b0001; st = 2; stage = 1; ticks = 0; end
               else ticks++;
             end
          2: if (tick) begin
               if (ticks == gaps[stage-1]) begin
                 rails[stage] = 1'b1; ticks = 0;
                 if (stage == 3) st = 3; else stage++;
               end else ticks++;
             end
          3: if (HAS_REQ && !rq) begin st = 4; ticks = 0; end
          4: if (tick) begin
               if (ticks == d_start) begin rails = 4'b0111; st = 5; stage = 2; ticks = 0; end
               else ticks++;
             end
          5: if (tick) begin
               if (ticks == gaps[stage]) begin
                 rails[stage] = 1'b0; ticks = 0;
                 if (stage == 0) st = 0; else stage--;
               end else ticks++;
             end
          default: st = 0;
        endcase
      end
      u2 = u1; u1 = uv; o2 = o1; o1 = ov; r2 = r1; r1 = req;
    end
  end
endmodule

module rail_sequencer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic        uv = 0, ov = 0, req = 0;
  logic [15:0] d_start = 0, d_ab = 0, d_bc = 0, d_cd = 0;
  int          tick_mode = 0;

  always #10 clk = ~clk;  // 50 MHz

  logic [3:0] en_a, en_b, en_c;
  logic       flt_a, flt_b, flt_c, dn_a, dn_b, dn_c;
  logic [2:0] st_a, st_b, st_c;

  rail_sequencer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .uv_ok_i(uv), .ov_trip_i(ov),
    .seq_req_i(req), .dly_start_i(d_start), .dly_ab_i(d_ab), .dly_bc_i(d_bc),
    .dly_cd_i(d_cd), .rail_en_o(en_a), .fault_o(flt_a), .state_o(st_a),
    .seq_done_o(dn_a)
  );

  rail_sequencer #(.EN_ACTIVE_HIGH(1'b0), .REQ_ACTIVE_HIGH(1'b0)) uut_inv (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .uv_ok_i(uv), .ov_trip_i(ov),
    .seq_req_i(~req), .dly_start_i(d_start), .dly_ab_i(d_ab), .dly_bc_i(d_bc),
    .dly_cd_i(d_cd), .rail_en_o(en_b), .fault_o(flt_b), .state_o(st_b),
    .seq_done_o(dn_b)
  );

  rail_sequencer #(.HAS_REQ(1'b0)) uut_nr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .uv_ok_i(uv), .ov_trip_i(ov),
    .seq_req_i(req), .dly_start_i(d_start), .dly_ab_i(d_ab), .dly_bc_i(d_bc),
    .dly_cd_i(d_cd), .rail_en_o(en_c), .fault_o(flt_c), .state_o(st_c),
    .seq_done_o(dn_c)
  );

  logic [3:0] m_rails, n_rails;
  int         m_st, n_st;
  logic       m_flt, n_flt, m_dn, n_dn;

  rs_ref_model #(.HAS_REQ(1'b1)) ref_main (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv(uv), .ov(ov), .req(req),
    .d_start(d_start), .d_ab(d_ab), .d_bc(d_bc), .d_cd(d_cd),
    .rails(m_rails), .st(m_st), .fault(m_flt), .done(m_dn)
  );

  rs_ref_model #(.HAS_REQ(1'b0)) ref_nr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv(uv), .ov(ov), .req(req),
    .d_start(d_start), .d_ab(d_ab), .d_bc(d_bc), .d_cd(d_cd),
    .rails(n_rails), .st(n_st), .fault(n_flt), .done(n_dn)
  );

  // timebase stimulus
  always @(negedge clk) begin
    if (tick_mode == 0) tick <= 1'b1;
    else                tick <= ($urandom_range(0, 2) == 0);
  end

  // ---------------- per-clock comparison against the model ----------------
  int chk_c = 0, err_c = 0;

  function automatic string tag_of(input int s);
    case (s)
      0:       return "R3";
      1:       return "R4";
      2, 3:    return "R5";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      string t;
      t = tag_of(m_st);
      chk_c += 6;
      if (en_a !== m_rails) begin err_c++; $display("FAIL %s rails act=%b exp=%b", t, en_a, m_rails); end
      if (st_a !== m_st[2:0]) begin err_c++; $display("FAIL %s state act=%0d exp=%0d", t, st_a, m_st); end
      if (dn_a !== m_dn) begin err_c++; $display("FAIL R5 done act=%b exp=%b", dn_a, m_dn); end
      if (flt_a !== m_flt) begin err_c++; $display("FAIL R2 fault act=%b exp=%b", flt_a, m_flt); end
      if (!(en_a inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111})) begin
        err_c++; $display("FAIL R6 thermometer act=%b exp=thermometer", en_a);
      end
      if (en_b !== ~m_rails || st_b !== m_st[2:0]) begin
        err_c++; $display("FAIL R10 inverted rails act=%b/%0d exp=%b/%0d", en_b, st_b, ~m_rails, m_st);
      end
      chk_c += 2;
      if (en_c !== n_rails || st_c !== n_st[2:0]) begin
        err_c++; $display("FAIL R11 no-request rails act=%b/%0d exp=%b/%0d", en_c, st_c, n_rails, n_st);
      end
      if (dn_c !== n_dn || flt_c !== n_flt || dn_b !== m_dn || flt_b !== m_flt) begin
        err_c++; $display("FAIL R10 flags act=%b%b%b%b exp=%b%b%b%b", dn_c, flt_c, dn_b, flt_b, n_dn, n_flt, m_dn, m_flt);
      end
    end
  end

  // ---------------- directed checks ----------------
  int chk_d = 0, err_d = 0;
  bit finished = 0;

  task automatic check(input string r, input int act, input int exp, input string what);
    chk_d++;
    if (act !== exp) begin
      err_d++;
      $display("FAIL %s %s act=%0d exp=%0d", r, what, act, exp);
    end
  endtask

  task automatic wait_state(input int s, input int limit, input string r);
    int n = 0;
    while (st_a != s[2:0] && n < limit) begin @(negedge clk); n++; end
    check(r, (st_a == s[2:0]) ? 1 : 0, 1, $sformatf("reach state %0d", s));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    check("R1", en_a, 0, "rails in reset");
    check("R1", en_b, 15, "inverted rails in reset");
    check("R1", st_a, 0, "state in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", en_a, 0, "rails after reset");
    check("R1", dn_a, 0, "done after reset");
    check("R2", flt_a, 1, "fault with supply low");

    // request without window: stay idle
    req = 1;
    cycles(20);
    check("R3", st_a, 0, "idle without window");
    check("R11", st_c, 0, "no-request build idle without window");

    // full power-up, tick every cycle
    d_start = 2; d_ab = 1; d_bc = 0; d_cd = 3;
    uv = 1;
    cycles(2);
    check("R2", flt_a, 0, "fault clears two edges after window");
    wait_state(3, 200, "R5");
    check("R5", en_a, 15, "all rails on");
    check("R11", st_c, 3, "no-request build all on");
    cycles(10);
    req = 0;
    wait_state(4, 20, "R7");
    wait_state(5, 50, "R7");
    check("R7", en_a, 7, "D off first");
    wait_state(0, 200, "R7");
    check("R7", en_a, 0, "all off after shutdown");
    check("R11", en_c, 15, "no-request build ignores request drop");

    // sparse ticks, zero start, loss of window mid ramp
    tick_mode = 1;
    d_start = 0; d_ab = 5; d_bc = 2; d_cd = 0;
    req = 1;
    wait_state(2, 200, "R5");
    cycles(2);
    ov = 1;
    cycles(2);
    check("R2", flt_a, 1, "fault two edges after trip");
    @(negedge clk);
    check("R9", en_a, 0, "all rails dropped on window loss");
    check("R9", st_a, 0, "idle after window loss");
    check("R11", en_c, 0, "no-request build drops together");
    cycles(5);
    ov = 0;

    // reassert request during shutdown
    d_start = 4; d_ab = 1; d_bc = 3; d_cd = 2;
    wait_state(3, 400, "R5");
    req = 0;
    wait_state(5, 200, "R7");
    req = 1;
    begin
      int n = 0;
      bit ok = 1;
      while (st_a != 3'd0 && n < 400) begin
        if (!(st_a inside {3'd4, 3'd5})) ok = 0;
        @(negedge clk); n++;
      end
      check("R8", ok, 1, "shutdown not interrupted");
      check("R8", st_a, 0, "shutdown reached idle");
    end
    wait_state(3, 400, "R8");

    // long delays, shutdown, then window loss on the no-request build
    tick_mode = 0;
    req = 0;
    wait_state(0, 400, "R7");
    d_start = 200; d_ab = 150; d_bc = 90; d_cd = 300;
    req = 1;
    wait_state(3, 2000, "R4");
    req = 0;
    wait_state(0, 2000, "R7");
    uv = 0;
    cycles(4);
    check("R11", en_c, 0, "no-request build off after window loss");
    check("R2", flt_c, 1, "no-request build fault");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", chk_c + chk_d, err_c + err_d);
    $finish;
  end

  // watchdog
  initial begin
    for (int i = 0; i < 100000; i++) @(negedge clk);
    if (!finished) begin
      $display("FAIL watchdog act=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", chk_c + chk_d + 1, err_c + err_d + 1);
      $finish;
    end
  end
endmodule